// File: doc/BRIEF.md
# Serial Read-Parity Checker with Sticky Error Flag

This block checks the parity of data words that arrive from a disc read channel one bit per qualified clock. A toggle register flips for every accepted zero bit. Odd parity is in force, so a good word carries an even number of zeros and leaves the toggle clear when the word ends. At the end-of-word strobe the toggle's state is merged into an error flag. The toggle then clears so that each word is judged on its own.

The error flag is sticky. Once a bad word has set it, later clean words do not clear it. Only the command that starts a new disc operation clears it. Software reads the flag as bit 0 of a status word, and every other bit of that word reads as zero. A word is a fixed number of bits long, 17 by default. Accepted bits beyond that length are ignored until the word ends. Deserialization and recovery of the disc timing take place upstream.

Top module: `disc_rd_parity_chk`

## Requirements
- R1: A synchronous, active-high reset clears the running parity, the error flag and the status word by the first clock edge at which it is sampled.
- R2: A bit is accepted when `bit_en` is 1. An accepted 0 inverts `run_par` at the next edge. An accepted 1 leaves `run_par` unchanged, and so does any cycle with `bit_en` at 0, whatever `rx_bit` carries.
- R3: Only the first WORD_BITS (17) accepted bits of a word are counted. Any further accepted bits before the word ends leave `run_par` unchanged.
- R4: When `word_end` is 1, the error flag becomes its old value OR the word's final parity. The final parity includes a bit accepted in that same cycle. At the same edge, `run_par` and the bit count return to zero.
- R5: Once the error flag is 1, a word that ends with a final parity of 0 leaves it at 1.
- R6: When `op_start` is 1, the error flag, `run_par` and the bit count clear at the next edge. This holds even if `word_end` or an accepted bit arrives in the same cycle.
- R7: `status_word` bit 0 equals the error flag, and bits STATUS_W-1..1 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Serial data bit from the read channel |
| bit_en | input | 1 | Qualifies `rx_bit` for this cycle |
| word_end | input | 1 | End-of-word strobe |
| op_start | input | 1 | Start of a new disc operation |
| run_par | output | 1 | Running parity of the current word (1 = odd zero count so far) |
| err_flag | output | 1 | Sticky parity error flag |
| status_word | output | STATUS_W | Status word with the error flag in bit 0 |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the last accepted bit and the end-of-word strobe. The bench sends sixteen ones and then a zero together with `word_end`, and it expects the flag to be set and `run_par` to be clear. The second pair is the operation start and the end-of-word strobe, which may also arrive together with an accepted bit. The bench first builds an odd running parity, then raises `op_start` and `word_end` together, and it expects both the flag and `run_par` to read zero after that edge.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  // Fold one serial bit into the zero-count parity.
  function automatic logic fold_zero(input logic par, input logic data, input logic take);
    return take ? (par ^ ~data) : par;
  endfunction

  // Merge a word's final parity into the sticky flag.
  function automatic logic merge_err(input logic err, input logic par);
    return err | par;
  endfunction

endpackage

// File: rtl/dpc_bit_counter.sv
module dpc_bit_counter #(
  parameter int WORD_BITS = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_en,
  output logic take,
  output logic full
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS);

  logic [CNT_W-1:0] cnt;

  assign full = (cnt == LAST);
  assign take = bit_en && !full;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (take)  cnt <= cnt + 1'b1;
  end

  // R3: a full word takes no further bits
  a_r3_no_take_when_full: assert property (@(posedge clk) disable iff (rst)
    full && !clr |=> full);
endmodule

// File: rtl/dpc_parity_toggle.sv
module dpc_parity_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clr_word,
  input  logic take,
  input  logic rx_bit,
  output logic run_par,
  output logic par_fold
);
  import dpc_pkg::*;

  assign par_fold = fold_zero(run_par, rx_bit, take);

  always_ff @(posedge clk) begin
    if (rst || clr_word) run_par <= 1'b0;
    else                 run_par <= par_fold;
  end

  // R2: an accepted one bit, or no accepted bit, keeps the parity
  a_r2_one_keeps: assert property (@(posedge clk) disable iff (rst)
    (!take || rx_bit) && !clr_word |=> run_par == $past(run_par));
  // R2: an accepted zero bit flips the parity
  a_r2_zero_flips: assert property (@(posedge clk) disable iff (rst)
    take && !rx_bit && !clr_word |=> run_par != $past(run_par));
endmodule

// File: rtl/dpc_sticky_flag.sv
module dpc_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic word_end,
  input  logic par_fold,
  output logic err
);
  import dpc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || start)  err <= 1'b0;
    else if (word_end) err <= merge_err(err, par_fold);
  end

  // R5: the flag stays set until an operation start
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    err && !start |=> err);
  // R4: a good word never sets the flag
  a_r4_clean_no_set: assert property (@(posedge clk) disable iff (rst)
    !err && !par_fold |=> !err);
endmodule

// File: rtl/disc_rd_parity_chk.sv
module disc_rd_parity_chk #(
  parameter int WORD_BITS = 17,
  parameter int STATUS_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_bit,
  input  logic                bit_en,
  input  logic                word_end,
  input  logic                op_start,
  output logic                run_par,
  output logic                err_flag,
  output logic [STATUS_W-1:0] status_word
);
  localparam int PAD_W = STATUS_W - 1;

  // named internal events
  logic clr_word;
  logic take;
  logic full;
  logic par_fold;

  assign clr_word = word_end || op_start;

  dpc_bit_counter #(.WORD_BITS(WORD_BITS)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_word), .bit_en(bit_en),
    .take(take), .full(full)
  );

  dpc_parity_toggle u_par (
    .clk(clk), .rst(rst), .clr_word(clr_word), .take(take),
    .rx_bit(rx_bit), .run_par(run_par), .par_fold(par_fold)
  );

  dpc_sticky_flag u_flag (
    .clk(clk), .rst(rst), .start(op_start), .word_end(word_end),
    .par_fold(par_fold), .err(err_flag)
  );

  assign status_word = {{PAD_W{1'b0}}, err_flag};

  // R6: an operation start clears everything, whatever else arrives
  a_r6_start_clears: assert property (@(posedge clk) disable iff (rst)
    op_start |=> !err_flag && !run_par);
  // R4: the running parity is clear after each end of word
  a_r4_par_clear_after_end: assert property (@(posedge clk) disable iff (rst)
    word_end |=> !run_par);
  // R3: bits past a full word leave the parity alone
  a_r3_extra_ignored: assert property (@(posedge clk) disable iff (rst)
    full && !clr_word |=> $stable(run_par));
  // R7: padding bits of the status word stay zero
  a_r7_status_pad: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_word[STATUS_W-1:1] == '0);
endmodule

// File: tb/disc_rd_parity_chk_test.sv
`timescale 1ns/100ps
module disc_rd_parity_chk_test;
  localparam int NB = 17;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst, rx_bit, bit_en, word_end, op_start;
  logic run_par, err_flag;
  logic [SW-1:0] status_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disc_rd_parity_chk #(.WORD_BITS(NB), .STATUS_W(SW)) uut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_en(bit_en),
    .word_end(word_end), .op_start(op_start),
    .run_par(run_par), .err_flag(err_flag), .status_word(status_word)
  );

  // {start_before, data[16:0], expect_bad, expect_sticky}
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 17'h1FFFF, 1'b0, 1'b0},
    {1'b0, 17'h1FFFE, 1'b1, 1'b1},
    {1'b0, 17'h1FFFF, 1'b0, 1'b1},
    {1'b1, 17'h00000, 1'b1, 1'b1},
    {1'b1, 17'h00001, 1'b0, 1'b0},
    {1'b0, 17'h0AAAA, 1'b1, 1'b1},
    {1'b1, 17'h15555, 1'b0, 1'b0},
    {1'b0, 17'h10001, 1'b1, 1'b1}
  };

  task automatic cyc(input logic b, input logic en, input logic we, input logic st);
    rx_bit = b; bit_en = en; word_end = we; op_start = st;
    @(posedge clk); #1;
    rx_bit = 1'b0; bit_en = 1'b0; word_end = 1'b0; op_start = 1'b0;
  endtask

  task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; rx_bit = 1'b0; bit_en = 1'b0; word_end = 1'b0; op_start = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk("R1 reset run_par", SW'(run_par), '0);
    chk("R1 reset err", SW'(err_flag), '0);
    chk("R1 reset status", status_word, '0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][19]) cyc(1'b0, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < NB; i++) cyc(VEC[v][2 + i], 1'b1, 1'b0, 1'b0);
      chk("R2 word parity", SW'(run_par), SW'(VEC[v][1]));
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      chk("R5 R4 sticky flag", SW'(err_flag), SW'(VEC[v][0]));
      chk("R7 status bit0", status_word, SW'(VEC[v][0]));
      chk("R4 parity cleared", SW'(run_par), '0);
    end

    // R2: rx_bit ignored when bit_en low
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 no enable no toggle", SW'(run_par), '0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 zero toggles", SW'(run_par), 16'd1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 idle holds", SW'(run_par), 16'd1);

    // R6: start and word_end together while parity is odd
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 short word sets flag", SW'(err_flag), 16'd1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 parity odd again", SW'(run_par), 16'd1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6 start beats end err", SW'(err_flag), '0);
    chk("R6 start beats end par", SW'(run_par), '0);

    // R3: bits past the word length are ignored
    for (int i = 0; i < NB; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3 extra bits ignored", SW'(run_par), '0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3 good word stays clean", SW'(err_flag), '0);

    // R4: last bit coincides with word_end
    for (int i = 0; i < NB - 1; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R4 coincident bit counted", SW'(err_flag), 16'd1);
    chk("R4 coincident parity cleared", SW'(run_par), '0);

    // R6: start with an accepted zero bit
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R6 start drops bit par", SW'(run_par), '0);
    chk("R6 start clears err", SW'(err_flag), '0);

    // R1: reset in mid operation
    cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 setup err", SW'(err_flag), 16'd1);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk("R1 mid reset par", SW'(run_par), '0);
    chk("R1 mid reset status", status_word, '0);

    done = 1'b1;
    finish_run();
  end
endmodule